// File: doc/BRIEF.md
# Debug-Port SRAM Partition Guard

This block owns a small single-port SRAM that is shared by a processor port and a debug-port memory path. A word-aligned boundary divides the RAM into two sections. The lower section runs from address zero to one word below the boundary, and the upper section runs from the boundary to the top of the RAM. The processor may read and write any word at any time. A debug access to the upper section is always allowed. A debug access to the lower section is allowed only while the protection input is low.

When a debug access is refused, a write leaves the RAM unchanged and a read returns zero. In both cases the block raises a one-cycle error pulse. The boundary comes from non-volatile storage. It arrives as a strobe that carries a byte address, and only the first strobe after reset is taken. The boundary is read back as a word index, which is the byte address with its two always-zero low bits removed.

The RAM has one access slot per cycle. The processor wins every conflict, and the debug side sees its ready signal held low until the slot is free.

Top module: `ram_debug_guard`

## Requirements
- R1: A processor access is carried out in every cycle it is requested, whatever the protection input and the boundary. Read data appears on `cpu_rdata` one cycle after the request.
- R2: If `cpu_req` and `dbg_req` are both high in a cycle, the processor is served and `dbg_ready` is low. A debug request is accepted only in a cycle where `dbg_req` and `dbg_ready` are both high.
- R3: `bnd_word` is 0 after reset. After a load it holds the loaded byte address shifted right by two, so 0x63C reads as 0x18F.
- R4: Only the first `bnd_load` strobe after reset changes the boundary. Later strobes are ignored.
- R5: An accepted debug access whose word index (address bits [10:2]) is greater than or equal to `bnd_word` is carried out whatever the protection input. Byte offsets within the boundary word, such as 0x63D, count as the upper section.
- R6: An accepted debug access whose word index is below `bnd_word` is carried out when `prot_on` is low at acceptance.
- R7: A debug write that is refused (below the boundary with `prot_on` high) does not modify the RAM. It gives `dbg_err` high for exactly the cycle after acceptance.
- R8: A debug read that is refused returns `dbg_rdata` = 0 with `dbg_rvalid` and `dbg_err` both high, in the cycle after acceptance.
- R9: Protection is judged from the value of `prot_on` at acceptance. Changing it in the response cycle does not alter that response.
- R10: An accepted debug read gives `dbg_rvalid` high for one cycle, the cycle after acceptance, with the data of the addressed word. Debug writes give no `dbg_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bnd_load | input | 1 | Boundary load strobe from non-volatile storage |
| bnd_value | input | 11 | Boundary byte address (low two bits ignored) |
| bnd_word | output | 9 | Boundary as a word index |
| prot_on | input | 1 | Memory protection active |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | Processor write enable |
| cpu_addr | input | 11 | Processor byte address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Processor read data, one cycle after request |
| dbg_req | input | 1 | Debug access request |
| dbg_we | input | 1 | Debug write enable |
| dbg_addr | input | 11 | Debug byte address |
| dbg_wdata | input | 32 | Debug write data |
| dbg_ready | output | 1 | Debug request accepted this cycle |
| dbg_rvalid | output | 1 | Debug read data valid |
| dbg_rdata | output | 32 | Debug read data, zero when refused |
| dbg_err | output | 1 | One-cycle pulse for a refused debug access |

## Verification
A processor access and a debug access can both be requested in the same cycle. The bench provokes this by raising `cpu_req` and `dbg_req` together. It checks that `dbg_ready` stays low while the processor read returns the correct word. It then checks that the stalled debug read completes once the processor releases the slot. A change of `prot_on` can also fall in the same cycle as a debug response. The bench flips protection during the response cycle of an allowed lower-section read, and checks that the data still arrives with no error.

// File: rtl/ram_debug_guard.sv
module ram_debug_guard #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bnd_load,
  input  logic [ADDR_W-1:0] bnd_value,
  output logic [ADDR_W-3:0] bnd_word,
  input  logic              prot_on,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              dbg_req,
  input  logic              dbg_we,
  input  logic [ADDR_W-1:0] dbg_addr,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic              dbg_ready,
  output logic              dbg_rvalid,
  output logic [DATA_W-1:0] dbg_rdata,
  output logic              dbg_err
);
  localparam int WA_W  = ADDR_W - 2;
  localparam int WORDS = 1 << WA_W;

  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] rd_q;
  logic [WA_W-1:0]   bnd_q;
  logic              bnd_set, ok_q, rvalid_q, err_q;
  logic              dbg_go, dbg_ok, ram_we;
  logic [WA_W-1:0]   ram_wa;
  logic [DATA_W-1:0] ram_wd;
  logic              unused_lowbits;

  assign unused_lowbits = &{1'b0, bnd_value[1:0], cpu_addr[1:0], dbg_addr[1:0]};

  assign dbg_ready = dbg_req & ~cpu_req;
  assign dbg_go    = dbg_req & dbg_ready;
  assign dbg_ok    = ~prot_on | (dbg_addr[ADDR_W-1:2] >= bnd_q);

  assign ram_we = cpu_req ? cpu_we : (dbg_go & dbg_we & dbg_ok);
  assign ram_wa = cpu_req ? cpu_addr[ADDR_W-1:2] : dbg_addr[ADDR_W-1:2];
  assign ram_wd = cpu_req ? cpu_wdata : dbg_wdata;

  always_ff @(posedge clk) begin
    if (ram_we) mem[ram_wa] <= ram_wd;
    rd_q <= mem[ram_wa];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bnd_q    <= '0;
      bnd_set  <= 1'b0;
      ok_q     <= 1'b0;
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (bnd_load && !bnd_set) begin
        bnd_q   <= bnd_value[ADDR_W-1:2];
        bnd_set <= 1'b1;
      end
      ok_q     <= dbg_ok;
      rvalid_q <= dbg_go & ~dbg_we;
      err_q    <= dbg_go & ~dbg_ok;
    end
  end

  assign bnd_word   = bnd_q;
  assign cpu_rdata  = rd_q;
  assign dbg_rvalid = rvalid_q;
  assign dbg_rdata  = (rvalid_q && ok_q) ? rd_q : '0;
  assign dbg_err    = err_q;
endmodule

module ram_debug_guard_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bnd_load,
  input logic [ADDR_W-3:0] bnd_word,
  input logic              prot_on,
  input logic              cpu_req,
  input logic              dbg_req,
  input logic              dbg_we,
  input logic [ADDR_W-1:0] dbg_addr,
  input logic              dbg_ready,
  input logic              dbg_rvalid,
  input logic [DATA_W-1:0] dbg_rdata,
  input logic              dbg_err
);
  logic seen_load;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen_load <= 1'b0;
    else if (bnd_load) seen_load <= 1'b1;

  assert_cpu_priority_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> !dbg_ready);
  assert_bnd_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seen_load |=> $stable(bnd_word));
  assert_upper_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && dbg_ready && dbg_addr[ADDR_W-1:2] >= bnd_word) |=> !dbg_err);
  assert_unprot_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && dbg_ready && !prot_on) |=> !dbg_err);
  assert_err_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_err |-> $past(dbg_req && dbg_ready));
  assert_blocked_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_err && dbg_rvalid) |-> dbg_rdata == '0);
  assert_rvalid_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_rvalid |-> $past(dbg_req && dbg_ready && !dbg_we));
endmodule

bind ram_debug_guard ram_debug_guard_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bnd_load(bnd_load), .bnd_word(bnd_word),
  .prot_on(prot_on), .cpu_req(cpu_req), .dbg_req(dbg_req), .dbg_we(dbg_we),
  .dbg_addr(dbg_addr), .dbg_ready(dbg_ready), .dbg_rvalid(dbg_rvalid),
  .dbg_rdata(dbg_rdata), .dbg_err(dbg_err));

// File: tb/ram_debug_guard_bench.sv
module ram_debug_guard_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bnd_load = 1'b0, prot_on = 1'b0;
  logic [10:0] bnd_value = '0, cpu_addr = '0, dbg_addr = '0;
  logic [8:0]  bnd_word;
  logic cpu_req = 1'b0, cpu_we = 1'b0, dbg_req = 1'b0, dbg_we = 1'b0;
  logic [31:0] cpu_wdata = '0, cpu_rdata, dbg_wdata = '0, dbg_rdata;
  logic dbg_ready, dbg_rvalid, dbg_err;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  ram_debug_guard u_ram_debug_guard (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu_op(input logic we, input logic [10:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic dbg_op(input logic we, input logic [10:0] a, input logic [31:0] d, input logic p);
    @(negedge clk);
    dbg_req = 1'b1; dbg_we = we; dbg_addr = a; dbg_wdata = d; prot_on = p;
    @(negedge clk);
    dbg_req = 1'b0; dbg_we = 1'b0;
  endtask

  // {we, prot, addr, wdata, expected rdata, expected err}
  localparam logic [77:0] VEC [12] = '{
    {1'b0, 1'b1, 11'h638, 32'h0,        32'h0,        1'b1},
    {1'b0, 1'b1, 11'h63C, 32'h0,        32'h33333333, 1'b0},
    {1'b0, 1'b1, 11'h63D, 32'h0,        32'h33333333, 1'b0},
    {1'b0, 1'b1, 11'h63B, 32'h0,        32'h0,        1'b1},
    {1'b0, 1'b1, 11'h7FC, 32'h0,        32'h44444444, 1'b0},
    {1'b0, 1'b0, 11'h000, 32'h0,        32'h11111111, 1'b0},
    {1'b1, 1'b1, 11'h000, 32'hDEAD0001, 32'h0,        1'b1},
    {1'b0, 1'b0, 11'h000, 32'h0,        32'h11111111, 1'b0},
    {1'b1, 1'b0, 11'h638, 32'h55555555, 32'h0,        1'b0},
    {1'b0, 1'b0, 11'h638, 32'h0,        32'h55555555, 1'b0},
    {1'b1, 1'b1, 11'h640, 32'h66666666, 32'h0,        1'b0},
    {1'b0, 1'b1, 11'h640, 32'h0,        32'h66666666, 1'b0}
  };

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R3 reset bnd", {23'h0, bnd_word}, 32'h0);
    chk("R10 reset rvalid", {31'h0, dbg_rvalid}, 32'h0);
    chk("R7 reset err", {31'h0, dbg_err}, 32'h0);
    rst_n = 1'b1;

    dbg_op(1'b1, 11'h010, 32'hA5A5A5A5, 1'b0);
    chk("R10 write no rvalid", {31'h0, dbg_rvalid}, 32'h0);
    dbg_op(1'b0, 11'h010, 32'h0, 1'b0);
    chk("R6 unloaded read", dbg_rdata, 32'hA5A5A5A5);
    chk("R10 rvalid", {31'h0, dbg_rvalid}, 32'h1);
    @(negedge clk);
    chk("R10 rvalid one cycle", {31'h0, dbg_rvalid}, 32'h0);

    @(negedge clk); bnd_load = 1'b1; bnd_value = 11'h63C;
    @(negedge clk); bnd_load = 1'b0;
    chk("R3 bnd word", {23'h0, bnd_word}, 32'h18F);
    bnd_load = 1'b1; bnd_value = 11'h100;
    @(negedge clk); bnd_load = 1'b0;
    @(negedge clk);
    chk("R4 second load ignored", {23'h0, bnd_word}, 32'h18F);

    prot_on = 1'b1;
    cpu_op(1'b1, 11'h000, 32'h11111111);
    cpu_op(1'b1, 11'h638, 32'h22222222);
    cpu_op(1'b1, 11'h63C, 32'h33333333);
    cpu_op(1'b1, 11'h7FC, 32'h44444444);
    cpu_op(1'b0, 11'h638, 32'h0);
    chk("R1 cpu lower under protection", cpu_rdata, 32'h22222222);

    for (int i = 0; i < 12; i++) begin
      dbg_op(VEC[i][77], VEC[i][75:65], VEC[i][64:33], VEC[i][76]);
      if (!VEC[i][77]) chk(VEC[i][0] ? "R8 blocked read" : "R5/R6 read", dbg_rdata, VEC[i][32:1]);
      chk(VEC[i][77] ? "R7 write err" : "R8 read err", {31'h0, dbg_err}, {31'h0, VEC[i][0]});
    end

    cpu_op(1'b0, 11'h000, 32'h0);
    chk("R7 cpu sees unchanged word", cpu_rdata, 32'h11111111);

    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 11'h7FC;
    dbg_req = 1'b1; dbg_we = 1'b0; dbg_addr = 11'h63C; prot_on = 1'b1;
    #1 chk("R2 ready low on conflict", {31'h0, dbg_ready}, 32'h0);
    @(negedge clk);
    chk("R1 cpu served on conflict", cpu_rdata, 32'h44444444);
    chk("R2 no debug response", {31'h0, dbg_rvalid}, 32'h0);
    cpu_req = 1'b0;
    #1 chk("R2 ready after release", {31'h0, dbg_ready}, 32'h1);
    @(negedge clk);
    dbg_req = 1'b0;
    chk("R2 stalled read done", dbg_rdata, 32'h33333333);

    @(negedge clk);
    dbg_req = 1'b1; dbg_we = 1'b0; dbg_addr = 11'h000; prot_on = 1'b0;
    @(negedge clk);
    dbg_req = 1'b0; prot_on = 1'b1;
    #1 chk("R9 data kept", dbg_rdata, 32'h11111111);
    chk("R9 no err", {31'h0, dbg_err}, 32'h0);

    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule